// File: doc/BRIEF.md
# Configuration-Space Target with Sized Memory Window

This block is the configuration-space side of a simple single-function add-in card on a parallel local bus. It answers type-0 configuration requests only while its device-select strobe (`idsel`) is high. Requests arrive on a reduced request bus: a valid strobe, a read/write flag, a dword register index, 32-bit write data and four byte enables. The bus handshake and parity logic sit outside this block and turn bus cycles into these requests.

The block holds fixed identification words and a command register that carries a memory-space enable. It also holds one memory base register, which enumeration software first sizes and then assigns. Until software writes a base, the base register reads back a size mask. The mask has ones in every address bit above the window size and zeros below it. Only the size-aligned upper bits can be written. The low four bits are fixed type bits: memory space, 32-bit decode, not prefetchable.

After software writes a base and sets the memory enable, the block raises a registered hit flag for every memory address that falls inside the assigned window. The rest of the card uses this flag to claim memory cycles.

Top module: `pcfg_target`

## Requirements
- R1: When `rst` is sampled high, the base register returns to the size mask (0xFFFF0000 for the default 64 KB window), the memory enable returns to 0 and `mem_hit` goes to 0.
- R2: While `idsel` is low, a request has no effect. A read gives `cfg_rvalid` = 0, and a write leaves every register unchanged.
- R3: Register index 0 reads {DEVICE_ID[31:16], VENDOR_ID[15:0]}. Register index 2 reads {CLASS_CODE[31:8], REVISION[7:0]}.
- R4: Base register index 4 always reads bits [WIN_LOG2-1:4] as 0 and bits [3:0] as the type code 0000.
- R5: Writing 0xFFFFFFFF to the base register with all byte enables set makes the next read return the size mask (0xFFFF0000 for a 64 KB window).
- R6: Writing a base to the base register makes later reads return that value's bits [31:WIN_LOG2], with the lower bits forced as in R4.
- R7: A write changes only the byte lanes whose byte enable is 1 (cfg_be[n] covers bits 8n+7..8n).
- R8: Command register index 1 reads 0 except bit 1, the memory enable. Bit 1 is written from cfg_wdata[1] only when cfg_be[0] = 1.
- R9: `mem_hit` is 1 one cycle after `mem_addr` is presented exactly when the memory enable is 1 and mem_addr[31:WIN_LOG2] equals the base register's bits [31:WIN_LOG2].
- R10: Reads of indices other than 0, 1, 2 and 4 return 0, and writes to those indices change no register.
- R11: An accepted read (cfg_sel = 1, cfg_we = 0, idsel = 1) drives `cfg_rvalid` = 1 and `cfg_rdata` on the cycle after the request is sampled. Otherwise `cfg_rvalid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idsel | input | 1 | Device select for configuration requests |
| cfg_sel | input | 1 | Configuration request valid |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_reg | input | 6 | Dword register index |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid |
| mem_addr | input | 32 | Memory address to decode |
| mem_hit | output | 1 | Registered window match |

## Verification
A corrupted base register shows up in two places: the next read of index 4 one cycle later, and `mem_hit` one cycle after an address that should or should not match. The bench therefore pairs every base write with a readback and with window-edge addresses. A stuck or wrongly decoded memory enable shows in `mem_hit` within one cycle of presenting an address inside the window. A leak through the select or byte-enable gating only shows on a later read of the register that was wrongly touched, so each ignored write is followed by such a read.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int REG_IDX_W = 6;
  typedef logic [REG_IDX_W-1:0] reg_idx_t;

  localparam reg_idx_t IDX_IDENT = 6'd0;
  localparam reg_idx_t IDX_CMD   = 6'd1;
  localparam reg_idx_t IDX_CLASS = 6'd2;
  localparam reg_idx_t IDX_BASE  = 6'd4;

  typedef struct packed {
    logic wr_cmd;
    logic wr_base;
    logic rd_acc;
  } acc_t;

  // Merge write data into an old word, one byte lane per enable bit.
  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pcfg_decode.sv
module pcfg_decode
  import pcfg_pkg::*;
(
  input  logic     idsel,
  input  logic     cfg_sel,
  input  logic     cfg_we,
  input  reg_idx_t cfg_reg,
  output acc_t     acc
);
  logic live;

  always_comb begin
    live        = idsel && cfg_sel;
    acc.rd_acc  = live && !cfg_we;
    acc.wr_cmd  = live && cfg_we && (cfg_reg == IDX_CMD);
    acc.wr_base = live && cfg_we && (cfg_reg == IDX_BASE);
  end
endmodule

// File: rtl/pcfg_base.sv
module pcfg_base #(
  parameter int       WIN_LOG2 = 16,
  parameter bit [3:0] TYPE_BITS = 4'b0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic [31:0] base_rd
);
  localparam logic [31:0] WMASK = ~((32'd1 << WIN_LOG2) - 32'd1);

  logic [31:0] base_q;
  logic [31:0] base_d;

  always_comb base_d = pcfg_pkg::lane_merge(base_q, wdata, be) & WMASK;

  always_ff @(posedge clk) begin
    if (rst)     base_q <= WMASK;
    else if (wr) base_q <= base_d;
  end

  assign base_rd = (base_q & WMASK) | {28'd0, TYPE_BITS};

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(base_rd)); // R6
  AST_BASE_LOW_FIXED: assert property (@(posedge clk) disable iff (rst)
    wr |=> (base_rd[3:0] == TYPE_BITS)); // R4
endmodule

// File: rtl/pcfg_cmd.sv
module pcfg_cmd (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic be0,
  input  logic wbit,
  output logic mem_en
);
  always_ff @(posedge clk) begin
    if (rst)            mem_en <= 1'b0;
    else if (wr && be0) mem_en <= wbit;
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mem_en)); // R8
endmodule

// File: rtl/pcfg_match.sv
module pcfg_match #(
  parameter int WIN_LOG2 = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mem_en,
  input  logic [31:0] base,
  input  logic [31:0] addr,
  output logic        hit
);
  localparam int HI_W = 32 - WIN_LOG2;

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= mem_en && (addr[31 -: HI_W] == base[31 -: HI_W]);
  end

  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(mem_en)); // R9
endmodule

// File: rtl/pcfg_target.sv
module pcfg_target
  import pcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h0A51,
  parameter logic [23:0] CLASS_CODE = 24'h030000,
  parameter logic [7:0]  REVISION   = 8'h01,
  parameter int          WIN_LOG2   = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        idsel,
  input  logic        cfg_sel,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_reg,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be,
  output logic [31:0] cfg_rdata,
  output logic        cfg_rvalid,
  input  logic [31:0] mem_addr,
  output logic        mem_hit
);
  acc_t        acc;
  logic [31:0] base_rd;
  logic        mem_en;
  logic [31:0] rd_mux;

  pcfg_decode u_dec (
    .idsel(idsel), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_reg(cfg_reg), .acc(acc)
  );

  pcfg_base #(.WIN_LOG2(WIN_LOG2), .TYPE_BITS(4'b0000)) u_base (
    .clk(clk), .rst(rst), .wr(acc.wr_base), .wdata(cfg_wdata),
    .be(cfg_be), .base_rd(base_rd)
  );

  pcfg_cmd u_cmd (
    .clk(clk), .rst(rst), .wr(acc.wr_cmd), .be0(cfg_be[0]),
    .wbit(cfg_wdata[1]), .mem_en(mem_en)
  );

  pcfg_match #(.WIN_LOG2(WIN_LOG2)) u_match (
    .clk(clk), .rst(rst), .mem_en(mem_en), .base(base_rd),
    .addr(mem_addr), .hit(mem_hit)
  );

  always_comb begin
    unique case (cfg_reg)
      IDX_IDENT: rd_mux = {DEVICE_ID, VENDOR_ID};
      IDX_CMD:   rd_mux = {30'd0, mem_en, 1'b0};
      IDX_CLASS: rd_mux = {CLASS_CODE, REVISION};
      IDX_BASE:  rd_mux = base_rd;
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata  <= 32'd0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rvalid <= acc.rd_acc;
      cfg_rdata  <= acc.rd_acc ? rd_mux : 32'd0;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (idsel && cfg_sel && !cfg_we) |=> cfg_rvalid); // R11
  AST_NO_IDSEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !idsel |=> !cfg_rvalid); // R2
endmodule

// File: tb/pcfg_target_tb_top.sv
module pcfg_target_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        idsel, cfg_sel, cfg_we;
  logic [5:0]  cfg_reg;
  logic [31:0] cfg_wdata, mem_addr, cfg_rdata;
  logic [3:0]  cfg_be;
  logic        cfg_rvalid, mem_hit;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pcfg_target dut_i (
    .clk(clk), .rst(rst), .idsel(idsel), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .mem_addr(mem_addr), .mem_hit(mem_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [5:0] r, input logic [31:0] d, input logic [3:0] be, input logic sel_dev);
    @(negedge clk);
    idsel = sel_dev; cfg_sel = 1'b1; cfg_we = 1'b1; cfg_reg = r; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    idsel = 1'b0; cfg_sel = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [5:0] r, input logic sel_dev, output logic [31:0] d, output logic v);
    @(negedge clk);
    idsel = sel_dev; cfg_sel = 1'b1; cfg_we = 1'b0; cfg_reg = r;
    @(negedge clk);
    d = cfg_rdata; v = cfg_rvalid;
    idsel = 1'b0; cfg_sel = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, output logic h);
    @(negedge clk);
    mem_addr = a;
    @(negedge clk);
    h = mem_hit;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic v, h;
    check("R1 hit after reset", {31'd0, mem_hit}, 32'd0);
    cfg_rd(6'd4, 1'b1, d, v);
    check("R1 base mask after reset", d, 32'hFFFF0000);
    check("R11 rvalid on read", {31'd0, v}, 32'd1);
    cfg_rd(6'd1, 1'b1, d, v);
    check("R1 command after reset", d, 32'd0);
    probe(32'hFFFF_0010, h);
    check("R1 no hit with enable off", {31'd0, h}, 32'd0);
  endtask

  task automatic t_ident;
    logic [31:0] d; logic v;
    cfg_rd(6'd0, 1'b1, d, v);
    check("R3 ident word", d, 32'h0A51C0DE);
    cfg_rd(6'd2, 1'b1, d, v);
    check("R3 class word", d, 32'h03000001);
    check("R11 rvalid class", {31'd0, v}, 32'd1);
  endtask

  task automatic t_no_idsel;
    logic [31:0] d; logic v;
    cfg_rd(6'd0, 1'b0, d, v);
    check("R2 no rvalid without idsel", {31'd0, v}, 32'd0);
    cfg_wr(6'd4, 32'h12340000, 4'hF, 1'b0);
    cfg_wr(6'd1, 32'h00000002, 4'hF, 1'b0);
    cfg_rd(6'd4, 1'b1, d, v);
    check("R2 base untouched", d, 32'hFFFF0000);
    cfg_rd(6'd1, 1'b1, d, v);
    check("R2 command untouched", d, 32'd0);
  endtask

  task automatic t_sizing;
    logic [31:0] d; logic v;
    cfg_wr(6'd4, 32'hFFFFFFFF, 4'hF, 1'b1);
    cfg_rd(6'd4, 1'b1, d, v);
    check("R5 sizing readback", d, 32'hFFFF0000);
    check("R4 low bits zero after sizing", {16'd0, d[15:0]}, 32'd0);
  endtask

  task automatic t_assign;
    logic [31:0] d; logic v;
    cfg_wr(6'd4, 32'h8765ABCD, 4'hF, 1'b1);
    cfg_rd(6'd4, 1'b1, d, v);
    check("R6 assigned base", d, 32'h87650000);
    check("R4 type bits", {28'd0, d[3:0]}, 32'd0);
  endtask

  task automatic t_partial;
    logic [31:0] d; logic v;
    cfg_wr(6'd4, 32'h11223344, 4'b1000, 1'b1);
    cfg_rd(6'd4, 1'b1, d, v);
    check("R7 upper byte only", d, 32'h11650000);
    cfg_wr(6'd1, 32'h00000002, 4'b1110, 1'b1);
    cfg_rd(6'd1, 1'b1, d, v);
    check("R7 command lane0 disabled", d, 32'd0);
  endtask

  task automatic t_cmd;
    logic [31:0] d; logic v;
    cfg_wr(6'd1, 32'hFFFFFFFF, 4'hF, 1'b1);
    cfg_rd(6'd1, 1'b1, d, v);
    check("R8 only enable bit", d, 32'h00000002);
  endtask

  task automatic t_match;
    logic h; logic [31:0] d; logic v;
    probe(32'h1165_1234, h);
    check("R9 inside window", {31'd0, h}, 32'd1);
    probe(32'h1165_FFFF, h);
    check("R9 top of window", {31'd0, h}, 32'd1);
    probe(32'h1166_0000, h);
    check("R9 above window", {31'd0, h}, 32'd0);
    probe(32'h1164_FFFF, h);
    check("R9 below window", {31'd0, h}, 32'd0);
    cfg_wr(6'd1, 32'h0, 4'h1, 1'b1);
    cfg_rd(6'd1, 1'b1, d, v);
    probe(32'h1165_0000, h);
    check("R9 disabled no hit", {31'd0, h}, 32'd0);
    cfg_wr(6'd1, 32'h2, 4'h1, 1'b1);
    probe(32'h1165_0000, h);
    check("R9 re-enabled hit", {31'd0, h}, 32'd1);
  endtask

  task automatic t_unimpl;
    logic [31:0] d; logic v;
    cfg_wr(6'd5, 32'hFFFFFFFF, 4'hF, 1'b1);
    cfg_wr(6'd3, 32'hFFFFFFFF, 4'hF, 1'b1);
    cfg_rd(6'd5, 1'b1, d, v);
    check("R10 unimplemented reads zero", d, 32'd0);
    check("R11 rvalid unimplemented", {31'd0, v}, 32'd1);
    cfg_rd(6'd3, 1'b1, d, v);
    check("R10 index 3 zero", d, 32'd0);
    cfg_rd(6'd4, 1'b1, d, v);
    check("R10 base unchanged", d, 32'h11650000);
    cfg_rd(6'd1, 1'b1, d, v);
    check("R10 command unchanged", d, 32'h00000002);
  endtask

  task automatic t_rereset;
    logic [31:0] d; logic v;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 hit cleared", {31'd0, mem_hit}, 32'd0);
    cfg_rd(6'd4, 1'b1, d, v);
    check("R1 base mask restored", d, 32'hFFFF0000);
    cfg_rd(6'd1, 1'b1, d, v);
    check("R1 enable cleared", d, 32'd0);
  endtask

  initial begin
    rst = 1'b1; idsel = 1'b0; cfg_sel = 1'b0; cfg_we = 1'b0;
    cfg_reg = '0; cfg_wdata = '0; cfg_be = '0; mem_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ident();
    t_no_idsel();
    t_sizing();
    t_assign();
    t_partial();
    t_cmd();
    t_match();
    t_unimpl();
    t_rereset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule